// File: doc/BRIEF.md
# Capture-Compare Status Flag Unit

This block holds the event flags of one timer channel that carries up to four capture/compare registers, named A, B, C and D. Each register has its own flag. In output-compare mode the flag rises when the free-running counter equals the register. In input-capture mode it rises on the capture strobe, which is the moment the counter value is copied into the register. The counter, the capture copy and the output waveform logic live outside this block. They reach it as the counter value, the register values and a per-register capture strobe.

Software can only clear flags, and only in two steps. It first reads the status word and sees the flag at 1. Its next write to the status word then carries a 0 in that flag's position. A transfer controller that a flag's interrupt has started can also clear the flag with a one-cycle acknowledge, unless the disable-select input is high. Each flag drives its own interrupt request, gated by a per-flag enable.

A parameter removes flags C and D for channel variants that lack those registers. In that case bits 2 and 3 of the status word read 0 and nothing can set them.

Top module: `ccsf_unit`

## Requirements
- R1: After reset all four flags read 0 and all interrupt requests are 0.
- R2: The status word has flag A in bit 0, B in bit 1, C in bit 2 and D in bit 3. A register whose mode bit is 0 (compare) sets its flag on the clock edge that ends a cycle in which the counter equals that register. Equality does not set the flag when the mode bit is 1.
- R3: A register whose mode bit is 1 (capture) sets its flag on the clock edge that ends a cycle with its capture strobe high. A capture strobe has no effect on a register in compare mode.
- R4: Writing 1 to a flag bit never changes that flag.
- R5: Writing 0 to a flag that has not been read as 1 since the last status write leaves the flag set.
- R6: A status read that returns a flag as 1 arms that flag. The next status write clears every armed flag whose written bit is 0 and disarms all flags, whatever data it carries.
- R7: A one-cycle acknowledge on a flag's transfer-controller input clears that flag when disable-select is 0. When disable-select is 1 the acknowledge has no effect.
- R8: When a set event and a clear request, from software or from an acknowledge, fall in the same cycle, the flag stays 1.
- R9: Each interrupt request output equals its flag ANDed with its enable bit. It follows a change of the enable in the same cycle.
- R10: With the upper flags disabled by parameter, bits 2 and 3 always read 0 and their interrupt requests stay 0, whatever events, writes or acknowledges arrive.
- R11: A flag that is cleared by any means loses its armed state. After it is set again, a write of 0 clears it only if a fresh read has seen it as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val | input | CNT_W | Current counter value |
| gr_flat | input | 4*CNT_W | Register values, A in the low slice up to D in the high slice |
| mode_ic | input | 4 | Per register: 1 = input capture, 0 = output compare |
| cap_evt | input | 4 | Per register capture strobe, one cycle |
| sts_rd | input | 1 | Status read strobe |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 4 | Status write data |
| ie | input | 4 | Per-flag interrupt enable |
| dtc_ack | input | 4 | Per-flag transfer-controller acknowledge pulse |
| dis_sel | input | 1 | Disable-select: 1 blocks acknowledge clears |
| sts_rdata | output | 4 | Status word (flags D..A) |
| irq | output | 4 | Per-flag interrupt requests |

## Verification
Flags are raised by counter equality and by capture strobes, each in both modes, which shows that the mode bit routes the right source and blocks the other. The clear path is tried with several write patterns: all ones, zero without a prior read, a mixed word after a read, and a repeated zero. These separate the read-arm condition from the write data and show that a write consumes the arm. Acknowledges with disable-select high and low, events colliding with clears, and a clear followed by a re-set without a new read cover the priority and arm-drop rules. A second instance built without the upper flags receives the same stimulus and must keep bits 2 and 3 at zero.

// File: rtl/ccsf_pkg.sv
package ccsf_pkg;

  localparam int NFLAG = 4;

  typedef enum logic {
    MODE_OC = 1'b0,
    MODE_IC = 1'b1
  } cc_mode_e;

  // Set has priority over any clear in the same cycle.
  function automatic logic flag_nxt(logic cur, logic set_i, logic clr_i);
    return set_i | (cur & ~clr_i);
  endfunction

  // Arm survives only while the flag is 1 and no status write occurs.
  function automatic logic arm_nxt(logic arm, logic cur, logic rd, logic wr);
    return cur & ~wr & (arm | rd);
  endfunction

endpackage

// File: rtl/ccsf_event_det.sv
module ccsf_event_det
  import ccsf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] gr_val,
  input  cc_mode_e         mode,
  input  logic             cap_pulse,
  output logic             set_evt
);

  logic cmp_hit;

  assign cmp_hit = (cnt_val == gr_val);

  always_comb begin
    unique case (mode)
      MODE_IC: set_evt = cap_pulse;
      default: set_evt = cmp_hit;
    endcase
  end

endmodule

// File: rtl/ccsf_flag_cell.sv
module ccsf_flag_cell
  import ccsf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  input  logic ack,
  input  logic dis_sel,
  output logic flag,
  output logic sw_clr,
  output logic dtc_clr
);

  logic arm_q;

  assign sw_clr  = wr_stb & arm_q & ~wr_bit;
  assign dtc_clr = ack & ~dis_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      flag  <= flag_nxt(flag, set_evt, sw_clr | dtc_clr);
      arm_q <= arm_nxt(arm_q, flag, rd_stb, wr_stb);
    end
  end

endmodule

// File: rtl/ccsf_unit.sv
module ccsf_unit
  import ccsf_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit HAS_CD = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W-1:0]       cnt_val,
  input  logic [4*CNT_W-1:0]     gr_flat,
  input  logic [3:0]             mode_ic,
  input  logic [3:0]             cap_evt,
  input  logic                   sts_rd,
  input  logic                   sts_wr,
  input  logic [3:0]             sts_wdata,
  input  logic [3:0]             ie,
  input  logic [3:0]             dtc_ack,
  input  logic                   dis_sel,
  output logic [3:0]             sts_rdata,
  output logic [3:0]             irq
);

  localparam logic [NFLAG-1:0] FLAG_MASK = HAS_CD ? 4'b1111 : 4'b0011;

  logic [NFLAG-1:0] raw_evt;
  logic [NFLAG-1:0] set_evt;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] sw_clr;
  logic [NFLAG-1:0] dtc_clr;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    ccsf_event_det #(.CNT_W(CNT_W)) u_det (
      .cnt_val   (cnt_val),
      .gr_val    (gr_flat[i*CNT_W +: CNT_W]),
      .mode      (cc_mode_e'(mode_ic[i])),
      .cap_pulse (cap_evt[i]),
      .set_evt   (raw_evt[i])
    );

    // Reserved flags never see a set event, so they stay at reset value.
    assign set_evt[i] = raw_evt[i] & FLAG_MASK[i];

    ccsf_flag_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_evt[i]),
      .rd_stb  (sts_rd),
      .wr_stb  (sts_wr),
      .wr_bit  (sts_wdata[i]),
      .ack     (dtc_ack[i]),
      .dis_sel (dis_sel),
      .flag    (flag_q[i]),
      .sw_clr  (sw_clr[i]),
      .dtc_clr (dtc_clr[i])
    );
  end

  assign sts_rdata = flag_q & FLAG_MASK;
  assign irq       = sts_rdata & ie;

endmodule

// File: rtl/ccsf_chk.sv
module ccsf_chk #(
  parameter int NF = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NF-1:0] flag_q,
  input logic [NF-1:0] set_evt,
  input logic [NF-1:0] sw_clr,
  input logic [NF-1:0] dtc_clr,
  input logic          sts_wr,
  input logic [NF-1:0] sts_wdata,
  input logic          dis_sel
);

  // R2 R3 R8: any set event lands in the flag on the next edge
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((flag_q & $past(set_evt)) == $past(set_evt)));

  // R4: a flag only rises after a set event
  a_r4_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & ~$past(set_evt)) == '0));

  // R6 R7: a flag only falls after a clear request
  a_r6_fall_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flag_q & $past(flag_q) & ~$past(sw_clr | dtc_clr)) == '0));

  // R6: software clear only during a write, only on bits written 0
  a_r6_sw_clr_on_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr != '0) |-> (sts_wr && ((sw_clr & sts_wdata) == '0)));

  // R7: acknowledge clears blocked by disable-select
  a_r7_dtc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (dtc_clr != '0) |-> !dis_sel);

endmodule

bind ccsf_unit ccsf_chk #(.NF(4)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flag_q    (flag_q),
  .set_evt   (set_evt),
  .sw_clr    (sw_clr),
  .dtc_clr   (dtc_clr),
  .sts_wr    (sts_wr),
  .sts_wdata (sts_wdata),
  .dis_sel   (dis_sel)
);

// File: tb/ccsf_unit_tb_top.sv
`timescale 1ns/1ps
module ccsf_unit_tb_top;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cnt_val;
  logic [4*CW-1:0] gr_flat;
  logic [3:0]    mode_ic, cap_evt, sts_wdata, ie, dtc_ack;
  logic          sts_rd, sts_wr, dis_sel;
  logic [3:0]    rdata, irq, rdata2, irq2;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ccsf_unit #(.CNT_W(CW), .HAS_CD(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .gr_flat(gr_flat),
    .mode_ic(mode_ic), .cap_evt(cap_evt), .sts_rd(sts_rd), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .ie(ie), .dtc_ack(dtc_ack), .dis_sel(dis_sel),
    .sts_rdata(rdata), .irq(irq)
  );

  ccsf_unit #(.CNT_W(CW), .HAS_CD(1'b0)) dut_nocd_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .gr_flat(gr_flat),
    .mode_ic(mode_ic), .cap_evt(cap_evt), .sts_rd(sts_rd), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .ie(ie), .dtc_ack(dtc_ack), .dis_sel(dis_sel),
    .sts_rdata(rdata2), .irq(irq2)
  );

  typedef struct {
    string      req;
    logic [3:0] flags;
    logic [3:0] irqs;
  } item_t;

  item_t sb_q[$];
  event  mon_ev;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Monitor: pops expected items and compares against both instances
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        string r2;
        it = sb_q.pop_front();
        n_chk++;
        if (rdata !== it.flags || irq !== it.irqs) begin
          n_fail++;
          $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b",
                   it.req, rdata, irq, it.flags, it.irqs);
        end
        r2 = (it.flags[3:2] != 2'b00) ? "R10" : it.req;
        n_chk++;
        if (rdata2 !== (it.flags & 4'b0011) || irq2 !== (it.irqs & 4'b0011)) begin
          n_fail++;
          $display("FAIL %s (no C/D): flags=%b irq=%b expected flags=%b irq=%b",
                   r2, rdata2, irq2, it.flags & 4'b0011, it.irqs & 4'b0011);
        end
      end
    end
  end

  // Driver side: push expected result and wake the monitor
  task automatic expect_now(string req, logic [3:0] f, logic [3:0] i);
    item_t it;
    it.req = req; it.flags = f; it.irqs = i;
    sb_q.push_back(it);
    ->mon_ev;
    #0.2;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_cnt(logic [CW-1:0] v);
    cnt_val = v; tick(); cnt_val = '0;
  endtask

  task automatic pulse_cap(logic [3:0] m);
    cap_evt = m; tick(); cap_evt = '0;
  endtask

  task automatic pulse_rd();
    sts_rd = 1'b1; tick(); sts_rd = 1'b0;
  endtask

  task automatic pulse_wr(logic [3:0] d);
    sts_wr = 1'b1; sts_wdata = d; tick(); sts_wr = 1'b0; sts_wdata = '0;
  endtask

  task automatic pulse_ack(logic [3:0] m, logic ds);
    dtc_ack = m; dis_sel = ds; tick(); dtc_ack = '0; dis_sel = 1'b0;
  endtask

  // Watchdog
  initial begin
    #(20000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cnt_val = '0;
    gr_flat = {16'h0040, 16'h0030, 16'h0020, 16'h0010};
    mode_ic = '0; cap_evt = '0; sts_rd = 1'b0; sts_wr = 1'b0;
    sts_wdata = '0; ie = '0; dtc_ack = '0; dis_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_now("R1", 4'b0000, 4'b0000);

    // R2: compare match on A sets bit 0
    pulse_cnt(16'h0010);
    expect_now("R2", 4'b0001, 4'b0000);
    // R2: equality on B in capture mode does nothing
    mode_ic = 4'b0010;
    pulse_cnt(16'h0020);
    expect_now("R2", 4'b0001, 4'b0000);
    // R3: capture strobe on B (capture mode) sets bit 1
    pulse_cap(4'b0010);
    expect_now("R3", 4'b0011, 4'b0000);
    // R3: capture strobe on C (compare mode) ignored
    pulse_cap(4'b0100);
    expect_now("R3", 4'b0011, 4'b0000);

    // R4: writing ones has no effect
    pulse_wr(4'b1111);
    expect_now("R4", 4'b0011, 4'b0000);
    // R5: writing zero without a read has no effect
    pulse_wr(4'b0000);
    expect_now("R5", 4'b0011, 4'b0000);

    // R6: read, then mixed write clears only A
    pulse_rd();
    pulse_wr(4'b1110);
    expect_now("R6", 4'b0010, 4'b0000);
    // R6: arm consumed, second zero write leaves B
    pulse_wr(4'b0000);
    expect_now("R6", 4'b0010, 4'b0000);
    pulse_rd();
    pulse_wr(4'b0000);
    expect_now("R6", 4'b0000, 4'b0000);

    // R7: acknowledge on C with disable-select high, then low
    pulse_cnt(16'h0030);
    expect_now("R2", 4'b0100, 4'b0000);
    pulse_ack(4'b0100, 1'b1);
    expect_now("R7", 4'b0100, 4'b0000);
    pulse_ack(4'b0100, 1'b0);
    expect_now("R7", 4'b0000, 4'b0000);

    // R8: set beats software clear and acknowledge clear
    pulse_cnt(16'h0040);
    expect_now("R2", 4'b1000, 4'b0000);
    pulse_rd();
    cnt_val = 16'h0040; sts_wr = 1'b1; sts_wdata = 4'b0000;
    tick();
    cnt_val = '0; sts_wr = 1'b0;
    expect_now("R8", 4'b1000, 4'b0000);
    cnt_val = 16'h0040; dtc_ack = 4'b1000; dis_sel = 1'b0;
    tick();
    cnt_val = '0; dtc_ack = '0;
    expect_now("R8", 4'b1000, 4'b0000);
    pulse_ack(4'b1000, 1'b0);
    expect_now("R7", 4'b0000, 4'b0000);

    // R9: interrupt requests follow flag AND enable
    pulse_cnt(16'h0010);
    pulse_cnt(16'h0030);
    ie = 4'b0101;
    #0.2;
    expect_now("R9", 4'b0101, 4'b0101);
    ie = 4'b0100;
    #0.2;
    expect_now("R9", 4'b0101, 4'b0100);
    ie = 4'b0000;

    // R11: clearing a flag drops its arm; re-set flag needs a fresh read
    pulse_rd();
    pulse_ack(4'b0001, 1'b0);
    expect_now("R7", 4'b0100, 4'b0000);
    pulse_cnt(16'h0010);
    pulse_wr(4'b0000);
    expect_now("R11", 4'b0001, 4'b0000);

    // R10: drive C and D events with everything enabled
    ie = 4'b1111;
    pulse_cnt(16'h0030);
    pulse_cnt(16'h0040);
    #0.2;
    expect_now("R10", 4'b1101, 4'b1101);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule